// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-channel SPI master behind a small word-addressed register port. Software programs a control word with the enable, the word size (one byte or two), the clock polarity and phase, and a 7-bit clock divider. It then writes a word to the data register. That write starts a full-duplex exchange on the serial clock, the outgoing data line and the incoming data line. When the exchange ends, the word received from the peripheral replaces the data register contents and a receive-full flag rises.

A status register reports two flags: busy and receive-full. One interrupt line combines two sources, "engine idle" and "receive-full". Each source has its own enable, and the control enable bit gates both. Chip select, buffering and DMA are handled elsewhere.

Register index on `bus_addr`: 0 is control, 1 is status, 2 is data, and 3 reads as zero. Control bits: 0 enable, 2 two-byte mode, 5 receive-full interrupt enable, 6 idle interrupt enable, 7 clock phase, 8 clock idle level, 15:9 divider. Status bits: 0 busy, 1 receive-full.

Top module: `regspi_master`

## Requirements
- R1: The reset state is as follows. Control, data, status and `bus_rdata` are zero. `spi_sclk`, `spi_mosi` and `irq` are low.
- R2: A write to index 0 stores all 16 bits. A read of index 0 returns them one cycle after the read access.
- R3: In one-byte mode (control bit 2 = 0), a data write made while enabled and idle does three things. It sets status bit 0 on the next clock edge. It shifts out bits 7:0, MSB first. It returns the received byte in bits 7:0 of the data register, with bits 15:8 zero.
- R4: In two-byte mode (control bit 2 = 1), bits 15:8 go out first and then bits 7:0, MSB first. The first received byte lands in bits 15:8 of the data register.
- R5: While idle, `spi_sclk` rests at control bit 8. A transfer makes 16 or 32 clock edges and ends at the idle level. Control bit 7 = 0 samples `spi_miso` on the leading edge of each bit; control bit 7 = 1 samples on the trailing edge.
- R6: Each `spi_sclk` half period lasts (divider + 1) system clocks, where the divider is control bits 15:9.
- R7: On the final edge, three changes occur in the same cycle: busy clears, receive-full (status bit 1) sets, and the received word is stored.
- R8: A read of index 2 returns the stored word and clears receive-full. After a finished transfer, the status then reads zero.
- R9: Writes to index 1 have no effect on the status flags.
- R10: A data write while busy is ignored. The ongoing transfer continues unchanged, and no second transfer follows.
- R11: A data write while control bit 0 is clear starts no transfer and leaves the data register unchanged.
- R12: `irq` is high only while control bit 0 is set. It rises when busy is clear and control bit 6 is set, or when receive-full is set and control bit 5 is set. It follows register changes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt, level |

## Verification
The bench sweeps every polarity/phase pair in both word sizes at several divider values. An attached peripheral model exchanges known words, so a swapped byte order, a wrong sampling edge or a wrong phase corrupts either the returned word or the word the model captured. It times every half period and counts every edge; an off-by-one divider or a stray extra edge shows up there. It also checks that busy clears and receive-full rises in the same status snapshot, which catches a design that updates them one cycle apart. Finally, it fires data writes mid-transfer and while disabled, writes to the status register, and walks the interrupt through each enable combination. A design that restarted on a late write, let status be written, or ignored the enable gate would show the wrong edge count, flag or `irq` level.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
  // Register indices on the bus.
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DATA = 2'd2;

  // Control bit positions (fixed layout).
  localparam int unsigned CB_ENA    = 0;
  localparam int unsigned CB_WIDE   = 2;
  localparam int unsigned CB_FULLIE = 5;
  localparam int unsigned CB_IDLEIE = 6;
  localparam int unsigned CB_CPHA   = 7;
  localparam int unsigned CB_CPOL   = 8;
  localparam int unsigned CB_DIV_LO = 9;

  // Status bit positions.
  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_FULL = 1;
endpackage

// File: rtl/regspi_tick.sv
// Half-period timer: pulses once every (div+1) clocks while run is high.
module regspi_tick #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/regspi_shift.sv
// Shift engine: latches mode at start, walks 2*N clock edges.
module regspi_shift #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wide_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [REG_W-1:0] tx_i,
  input  logic             miso_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [REG_W-1:0] rx_word_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic [DIV_W-1:0] div_o,
  output logic             cpol_o
);
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned EDGE_W = $clog2(2 * REG_W);
  localparam logic [EDGE_W-1:0] LAST_WIDE = EDGE_W'(2 * REG_W - 1);
  localparam logic [EDGE_W-1:0] LAST_HALF = EDGE_W'(2 * HALF_W - 1);

  logic             busy_q, wide_q, cpha_q, cpol_q, sclk_q;
  logic [DIV_W-1:0] div_q;
  logic [REG_W-1:0] tx_q, rx_q, rx_next;
  logic [EDGE_W-1:0] edge_q;
  logic             lead, sample, shift_en, last;

  // Even edge index = leading edge of a bit.
  assign lead     = ~edge_q[0];
  assign sample   = lead ^ cpha_q;
  assign shift_en = ~sample && (edge_q != '0);
  assign last     = edge_q == (wide_q ? LAST_WIDE : LAST_HALF);
  assign rx_next  = sample ? {rx_q[REG_W-2:0], miso_i} : rx_q;

  assign done_o = busy_q & tick_i & last;
  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[REG_W-1];
  assign div_o  = div_q;
  assign cpol_o = cpol_q;

  always_comb begin
    if (wide_q) rx_word_o = rx_next;
    else        rx_word_o = {{(REG_W-HALF_W){1'b0}}, rx_next[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wide_q <= 1'b0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else if (!busy_q) begin
      sclk_q <= cpol_i;
      if (start) begin
        busy_q <= 1'b1;
        wide_q <= wide_i;
        cpha_q <= cpha_i;
        cpol_q <= cpol_i;
        div_q  <= div_i;
        edge_q <= '0;
        rx_q   <= '0;
        tx_q   <= wide_i ? tx_i : {tx_i[HALF_W-1:0], {HALF_W{1'b0}}};
      end else begin
        tx_q <= '0;
      end
    end else if (tick_i) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + EDGE_W'(1);
      rx_q   <= rx_next;
      if (shift_en) tx_q <= {tx_q[REG_W-2:0], 1'b0};
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regspi_irq.sv
// Registered interrupt combiner, gated by the block enable.
module regspi_irq (
  input  logic clk,
  input  logic rst,
  input  logic ena,
  input  logic idle_ie,
  input  logic full_ie,
  input  logic busy,
  input  logic full,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ena & ((idle_ie & ~busy) | (full_ie & full));
  end
endmodule

// File: rtl/regspi_master.sv
module regspi_master
  import regspi_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  localparam int unsigned DIV_W = REG_W - CB_DIV_LO;

  logic [REG_W-1:0] ctrl_q, data_q, status_w, rx_word;
  logic             full_q;
  logic             ena, busy, done, tick, cpol_lat;
  logic [DIV_W-1:0] div_lat;
  logic             wr_ctrl, wr_stat, wr_data, rd_data, start;

  assign wr_ctrl = bus_en &  bus_we & (bus_addr == ADR_CTRL);
  assign wr_stat = bus_en &  bus_we & (bus_addr == ADR_STAT);
  assign wr_data = bus_en &  bus_we & (bus_addr == ADR_DATA);
  assign rd_data = bus_en & ~bus_we & (bus_addr == ADR_DATA);
  assign ena     = ctrl_q[CB_ENA];
  assign start   = wr_data & ena & ~busy;

  always_comb begin
    status_w          = '0;
    status_w[SB_BUSY] = busy;
    status_w[SB_FULL] = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      full_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (done) begin
        data_q <= rx_word;
        full_q <= 1'b1;
      end else if (rd_data) begin
        full_q <= 1'b0;
      end
      bus_rdata <= '0;
      if (bus_en && !bus_we) begin
        case (bus_addr)
          ADR_CTRL: bus_rdata <= ctrl_q;
          ADR_STAT: bus_rdata <= status_w;
          ADR_DATA: bus_rdata <= data_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  regspi_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_lat),
    .tick (tick)
  );

  regspi_shift #(.REG_W(REG_W), .DIV_W(DIV_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wide_i    (ctrl_q[CB_WIDE]),
    .cpol_i    (ctrl_q[CB_CPOL]),
    .cpha_i    (ctrl_q[CB_CPHA]),
    .div_i     (ctrl_q[REG_W-1:CB_DIV_LO]),
    .tx_i      (bus_wdata),
    .miso_i    (spi_miso),
    .tick_i    (tick),
    .busy_o    (busy),
    .done_o    (done),
    .rx_word_o (rx_word),
    .sclk_o    (spi_sclk),
    .mosi_o    (spi_mosi),
    .div_o     (div_lat),
    .cpol_o    (cpol_lat)
  );

  regspi_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .ena     (ena),
    .idle_ie (ctrl_q[CB_IDLEIE]),
    .full_ie (ctrl_q[CB_FULLIE]),
    .busy    (busy),
    .full    (full_q),
    .irq_o   (irq)
  );
endmodule

// File: rtl/regspi_sva.sv
module regspi_sva (
  input logic clk,
  input logic rst,
  input logic ena,
  input logic wr_data,
  input logic wr_stat,
  input logic busy,
  input logic done,
  input logic full,
  input logic irq,
  input logic sclk,
  input logic cpol_lat
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !ena |=> !irq); // R12

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !ena && !busy) |=> !busy); // R11

  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    done |=> (full && !busy)); // R7

  AST_STATUS_READONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !done) |=> $stable(full)); // R9

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy && !done) |=> busy); // R10

  AST_SCLK_HOME: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sclk == cpol_lat)); // R5
endmodule

bind regspi_master regspi_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .ena      (ena),
  .wr_data  (wr_data),
  .wr_stat  (wr_stat),
  .busy     (busy),
  .done     (done),
  .full     (full_q),
  .irq      (irq),
  .sclk     (spi_sclk),
  .cpol_lat (cpol_lat)
);

// File: tb/regspi_master_tb.sv
`timescale 1ns/1ps
module regspi_master_tb;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, irq;

  int errors = 0;
  int checks = 0;

  // Peripheral model state
  logic [15:0] s_tx = '0, s_rx = '0;
  int          s_edges = 0;
  bit          s_act = 1'b0, s_pha = 1'b0;
  logic        mosi_d = 1'b0;
  // Half-period monitor
  int   hp_exp = 1, hp_cnt = 0, hp_bad = 0;
  bit   hp_seen = 1'b0;
  logic hp_last = 1'b0;

  always #2.5 clk = ~clk;

  assign spi_miso = s_tx[15];

  regspi_master u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
  );

  always @(negedge clk) begin
    mosi_d = spi_mosi;
    if (s_act) begin
      if (spi_sclk != hp_last) begin
        if (hp_seen && hp_cnt != hp_exp) hp_bad++;
        hp_seen = 1'b1;
        hp_cnt  = 1;
        hp_last = spi_sclk;
      end else begin
        hp_cnt++;
      end
    end
  end

  always @(spi_sclk) begin
    if (s_act) begin
      if ((s_edges % 2 == 0) ^ s_pha) s_rx = {s_rx[14:0], mosi_d};
      else if (s_edges != 0)          s_tx = {s_tx[14:0], 1'b0};
      s_edges++;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output logic [15:0] st);
    st = 16'h0001;
    for (int i = 0; i < 400; i++) begin
      bus_read(A_STAT, st);
      if (!st[0]) break;
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit ena, input bit wide, input bit pha,
                                          input bit pol, input int dv);
    logic [15:0] c;
    c = '0;
    c[0] = ena; c[2] = wide; c[7] = pha; c[8] = pol; c[15:9] = 7'(dv);
    return c;
  endfunction

  task automatic arm_slave(input bit wide, input bit pha, input int dv, input logic [15:0] sw);
    s_tx = wide ? sw : {sw[7:0], 8'h00};
    s_rx = '0; s_edges = 0; s_pha = pha;
    hp_exp = dv + 1; hp_seen = 1'b0; hp_cnt = 0; hp_bad = 0; hp_last = spi_sclk;
    s_act = 1'b1;
  endtask

  task automatic run_xfer(input bit wide, input bit pol, input bit pha, input int dv,
                          input logic [15:0] tw, input logic [15:0] sw);
    logic [15:0] st, rd, expd, expm, got;
    int n;
    n = wide ? 16 : 8;
    bus_write(A_CTRL, mk_ctrl(1'b1, wide, pha, pol, dv));
    @(negedge clk); @(negedge clk);
    chk(spi_sclk == pol, "R5 idle clock level", 32'(spi_sclk), 32'(pol));
    arm_slave(wide, pha, dv, sw);
    bus_write(A_DATA, tw);
    bus_read(A_STAT, st);
    chk(st[0] == 1'b1, "R3 busy after start", 32'(st), 32'h1);
    wait_idle(st);
    chk(st == 16'h0002, "R7 busy clear with full set", 32'(st), 32'h2);
    chk(s_edges == 2 * n, "R5 edge count", 32'(s_edges), 32'(2 * n));
    chk(hp_bad == 0, "R6 half period length", 32'(hp_bad), 32'h0);
    bus_read(A_DATA, rd);
    expd = wide ? sw : {8'h00, sw[7:0]};
    chk(rd == expd, wide ? "R4 received word" : "R3 received byte", 32'(rd), 32'(expd));
    expm = wide ? tw : {8'h00, tw[7:0]};
    got  = wide ? s_rx : {8'h00, s_rx[7:0]};
    chk(got == expm, wide ? "R4 transmitted word" : "R3 transmitted byte", 32'(got), 32'(expm));
    bus_read(A_STAT, st);
    chk(st == 16'h0000, "R8 status cleared by data read", 32'(st), 32'h0);
    s_act = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd, st;
    int idx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1 serial pins low", {30'h0, spi_sclk, spi_mosi}, 32'h0);
    chk(irq == 1'b0, "R1 irq low", 32'(irq), 32'h0);
    chk(bus_rdata == 16'h0, "R1 read port zero", 32'(bus_rdata), 32'h0);
    bus_read(A_CTRL, rd); chk(rd == 16'h0, "R1 control zero", 32'(rd), 32'h0);
    bus_read(A_STAT, rd); chk(rd == 16'h0, "R1 status zero", 32'(rd), 32'h0);
    bus_read(A_DATA, rd); chk(rd == 16'h0, "R1 data zero", 32'(rd), 32'h0);

    // R2 control readback (enable clear)
    bus_write(A_CTRL, 16'hB5A4);
    bus_read(A_CTRL, rd); chk(rd == 16'hB5A4, "R2 control readback", 32'(rd), 32'hB5A4);
    bus_write(A_CTRL, 16'h0000);

    // R9 status write at reset state
    bus_write(A_STAT, 16'hFFFF);
    bus_read(A_STAT, rd); chk(rd == 16'h0, "R9 status write ignored", 32'(rd), 32'h0);

    // Sweep: sizes x modes x dividers
    idx = 0;
    for (int w = 0; w < 2; w++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 3; d++) begin
          run_xfer(w[0], m[1], m[0], (d == 2) ? 3 : d,
                   16'hA5C3 ^ 16'(idx * 16'h1357), 16'h3C96 + 16'(idx * 16'h0F1F));
          idx++;
        end
      end
    end

    // R10: write while busy is ignored
    bus_write(A_CTRL, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 7));
    @(negedge clk); @(negedge clk);
    arm_slave(1'b1, 1'b0, 7, 16'h81E7);
    bus_write(A_DATA, 16'h6D2B);
    bus_write(A_DATA, 16'hFFFF);
    bus_write(A_DATA, 16'h0000);
    wait_idle(st);
    chk(s_rx == 16'h6D2B, "R10 first word kept", 32'(s_rx), 32'h6D2B);
    chk(s_edges == 32, "R10 single transfer edges", 32'(s_edges), 32'd32);
    repeat (6) @(negedge clk);
    bus_read(A_STAT, st);
    chk(st == 16'h0002, "R10 no second transfer", 32'(st), 32'h2);
    // R9 status write while full
    bus_write(A_STAT, 16'h0000);
    bus_read(A_STAT, st); chk(st == 16'h0002, "R9 full survives status write", 32'(st), 32'h2);
    bus_write(A_STAT, 16'hFFFD);
    bus_read(A_STAT, st); chk(st == 16'h0002, "R9 status bits not writable", 32'(st), 32'h2);
    bus_read(A_DATA, rd); chk(rd == 16'h81E7, "R10 received word", 32'(rd), 32'h81E7);
    s_act = 1'b0;

    // R11: write while disabled
    bus_write(A_CTRL, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b0, 0));
    @(negedge clk);
    arm_slave(1'b1, 1'b0, 0, 16'h1234);
    bus_write(A_DATA, 16'h4321);
    repeat (40) @(negedge clk);
    bus_read(A_STAT, st); chk(st == 16'h0, "R11 no busy when disabled", 32'(st), 32'h0);
    chk(s_edges == 0, "R11 no clock edges", 32'(s_edges), 32'h0);
    bus_read(A_DATA, rd); chk(rd == 16'h81E7, "R11 data unchanged", 32'(rd), 32'h81E7);
    s_act = 1'b0;

    // R12 interrupt combinations
    bus_write(A_CTRL, 16'h0040);
    @(negedge clk);
    chk(irq == 1'b0, "R12 idle source gated by enable", 32'(irq), 32'h0);
    bus_write(A_CTRL, 16'h0041);
    @(negedge clk);
    chk(irq == 1'b1, "R12 idle source fires", 32'(irq), 32'h1);
    bus_write(A_DATA, 16'h00A5);
    @(negedge clk);
    chk(irq == 1'b0, "R12 idle source low while busy", 32'(irq), 32'h0);
    wait_idle(st);
    @(negedge clk);
    chk(irq == 1'b1, "R12 idle source back after transfer", 32'(irq), 32'h1);
    bus_write(A_CTRL, 16'h0021);
    @(negedge clk);
    chk(irq == 1'b1, "R12 full source fires", 32'(irq), 32'h1);
    bus_write(A_CTRL, 16'h0020);
    @(negedge clk);
    chk(irq == 1'b0, "R12 full source gated by enable", 32'(irq), 32'h0);
    bus_write(A_CTRL, 16'h0021);
    @(negedge clk);
    chk(irq == 1'b1, "R12 full source re-enabled", 32'(irq), 32'h1);
    bus_read(A_DATA, rd);
    @(negedge clk);
    chk(irq == 1'b0, "R12 full source clears on data read", 32'(irq), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule